// File: doc/BRIEF.md
# Reset Control Port Register

This block is a one-byte register that sits at a single I/O address, 0xCF9 by default. Software uses it to request a processor reset or a full platform reset. Byte writes that hit the address update the stored value. Byte reads at the address return that value, except that the trigger bit always reads as zero.

A write raises a reset request only when it sets the trigger bit (bit 2) while the stored copy of that bit is still clear. Bit 1 of the same byte picks the kind of reset:

- When bit 1 is clear, only a processor reset pulse is produced.
- When bit 1 is set, a system-wide hard reset pulse is produced as well, in the same cycle. The system sequencer fans that pulse out to storage, keyboard, bus and legacy-port logic.

The block only produces these request pulses. Sequencing the peripherals belongs elsewhere.

Top module: `rst_ctl_port`

## Requirements
- R1: Only accesses at the configured address (default 0xCF9) have any effect. A write to another address leaves the stored value unchanged and produces no pulse. A read at another address, or with no read strobe, returns 0x00.
- R2: After a write at the address, the stored value equals the written byte with bit 1 forced to 0.
- R3: A read at the address returns the stored value with bit 2 forced to 0, combinationally in the same cycle as the read strobe.
- R4: While reset is asserted, and after it is released, the stored value is 0x00 and both pulse outputs are low.
- R5: A write at the address with bit 2 = 1, when the stored bit 2 is 0, makes `cpu_reset_pulse` high for exactly the one cycle after the write's clock edge.
- R6: A write that triggers per R5 with bit 1 = 1 also drives `sys_reset_pulse` high in that same cycle. A triggering write with bit 1 = 0 leaves `sys_reset_pulse` low.
- R7: A write with bit 2 = 1 while the stored bit 2 is already 1 produces no pulse.
- R8: A write with bit 2 = 0 produces no pulse, and it clears the stored bit 2 so that a later write with bit 2 = 1 triggers again.
- R9: `sys_reset_pulse` is never high without `cpu_reset_pulse`, and neither pulse lasts longer than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Byte write strobe, one cycle per access |
| io_rd | input | 1 | Byte read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data: masked stored value on a hit, otherwise 0x00 |
| cpu_reset_pulse | output | 1 | One-cycle processor reset request |
| sys_reset_pulse | output | 1 | One-cycle platform hard reset request |

## Verification
Writes of 0x06 and 0x04 from a cleared register separate the hard-reset path from the processor-only path. Repeating 0x06 while bit 2 is already stored shows that only an edge of that bit triggers. A write of 0xF3, followed by reads, shows that bit 1 is dropped on store and bit 2 is hidden on read while the other bits pass through. A write of 0x04 to a neighbouring address, followed by a real trigger at 0xCF9, tells true address decoding apart from a partial-address match. A mid-run reset tells a cleared register apart from one that keeps its value.

// File: rtl/rcp_pkg.sv
package rcp_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              cpu_pls;
        logic              sys_pls;
    } rcp_state_t;

    localparam rcp_state_t RCP_RESET = '{value: '0, cpu_pls: 1'b0, sys_pls: 1'b0};
endpackage

// File: rtl/rcp_decode.sv
module rcp_decode #(
    parameter int               ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hCF9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              wr_hit,
    output logic              rd_hit
);
    logic match;

    assign match  = (addr == BASE_ADDR);
    assign wr_hit = wr & match;
    assign rd_hit = rd & match;
endmodule

// File: rtl/rcp_core.sv
module rcp_core
    import rcp_pkg::*;
#(
    parameter int ARM_BIT = 2,
    parameter int SEL_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value_q,
    output logic              cpu_pls,
    output logic              sys_pls
);
    rcp_state_t st_d, st_q;
    logic       fire;

    // Trigger only on a rising edge of the arm bit, judged against the stored copy.
    assign fire = wr_hit & ~st_q.value[ARM_BIT] & wdata[ARM_BIT];

    always_comb begin
        st_d         = st_q;
        st_d.cpu_pls = 1'b0;
        st_d.sys_pls = 1'b0;
        if (wr_hit) begin
            st_d.value          = wdata;
            st_d.value[SEL_BIT] = 1'b0;
            st_d.cpu_pls        = fire;
            st_d.sys_pls        = fire & wdata[SEL_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RCP_RESET;
        else        st_q <= st_d;
    end

    assign value_q = st_q.value;
    assign cpu_pls = st_q.cpu_pls;
    assign sys_pls = st_q.sys_pls;
endmodule

// File: rtl/rcp_readmux.sv
module rcp_readmux
    import rcp_pkg::*;
#(
    parameter int ARM_BIT = 2
) (
    input  logic              rd_hit,
    input  logic [DATA_W-1:0] value,
    output logic [DATA_W-1:0] rdata
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == ARM_BIT) begin : g_hide
            assign rdata[i] = 1'b0;
        end else begin : g_pass
            assign rdata[i] = rd_hit & value[i];
        end
    end
endmodule

// File: rtl/rst_ctl_port.sv
module rst_ctl_port
    import rcp_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hCF9,
    parameter int                ARM_BIT   = 2,
    parameter int                SEL_BIT   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              cpu_reset_pulse,
    output logic              sys_reset_pulse
);
    logic              wr_hit, rd_hit;
    logic [DATA_W-1:0] reg_q;

    rcp_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr(io_addr), .wr(io_wr), .rd(io_rd), .wr_hit(wr_hit), .rd_hit(rd_hit)
    );

    rcp_core #(.ARM_BIT(ARM_BIT), .SEL_BIT(SEL_BIT)) u_core (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(io_wdata),
        .value_q(reg_q), .cpu_pls(cpu_reset_pulse), .sys_pls(sys_reset_pulse)
    );

    rcp_readmux #(.ARM_BIT(ARM_BIT)) u_rmux (
        .rd_hit(rd_hit), .value(reg_q), .rdata(io_rdata)
    );
endmodule

// File: rtl/rst_ctl_port_chk.sv
module rst_ctl_port_chk #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hCF9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic [7:0]        reg_q,
    input logic              cpu_reset_pulse,
    input logic              sys_reset_pulse
);
    p_offaddr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr == BASE_ADDR) |=> $stable(reg_q));

    p_offaddr_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr != BASE_ADDR) |-> io_rdata == 8'h00);

    p_store_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == BASE_ADDR) |=> reg_q[1] == 1'b0);

    p_read_hide_r3: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata[2] == 1'b0);

    p_pulse_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reset_pulse |-> ($past(io_wr) && $past(io_addr) == BASE_ADDR && $past(io_wdata[2])));

    p_no_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == BASE_ADDR && reg_q[2]) |=> !cpu_reset_pulse);

    p_hard_with_cpu_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_pulse |-> cpu_reset_pulse);

    p_single_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reset_pulse |=> !cpu_reset_pulse);
endmodule

bind rst_ctl_port rst_ctl_port_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .reg_q(reg_q),
    .cpu_reset_pulse(cpu_reset_pulse), .sys_reset_pulse(sys_reset_pulse)
);

// File: tb/rst_ctl_port_test.sv
module rst_ctl_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        cpu_reset_pulse, sys_reset_pulse;

    int   vectors = 0;
    int   miscompares = 0;
    bit   done = 0;

    // behavioural reference state
    int   m_reg = 0;
    int   e_cpu = 0;
    int   e_sys = 0;
    string e_tag = "R4";

    always #4 clk = ~clk;

    rst_ctl_port uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cpu_reset_pulse(cpu_reset_pulse), .sys_reset_pulse(sys_reset_pulse)
    );

    task automatic cmp(input string tag, input string what, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s %s got 0x%0h expected 0x%0h", tag, what, got, exp);
        end
    endtask

    // One bus cycle: check pulses from the previous edge, drive, check read data, predict.
    task automatic step(input logic [15:0] a, input bit w, input bit r,
                        input logic [7:0] d, input string tag);
        int hit;
        @(negedge clk);
        cmp(e_tag, "cpu_reset_pulse", int'(cpu_reset_pulse), e_cpu);
        cmp(e_tag, "sys_reset_pulse", int'(sys_reset_pulse), e_sys);
        io_addr = a; io_wr = w; io_rd = r; io_wdata = d;
        #1;
        hit = (a == 16'hCF9);
        cmp(tag, "io_rdata", int'(io_rdata), (r && hit) ? (m_reg & 8'hFB) : 0);
        if (w && hit) begin
            e_cpu = (((m_reg >> 2) & 1) == 0 && d[2]) ? 1 : 0;
            e_sys = (e_cpu == 1 && d[1]) ? 1 : 0;
            m_reg = d & 8'hFD;
        end else begin
            e_cpu = 0;
            e_sys = 0;
        end
        e_tag = tag;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        io_wr = 0; io_rd = 0;
        rst_n = 0;
        repeat (2) @(negedge clk);
        cmp("R4", "cpu_reset_pulse in reset", int'(cpu_reset_pulse), 0);
        cmp("R4", "sys_reset_pulse in reset", int'(sys_reset_pulse), 0);
        rst_n = 1;
        m_reg = 0; e_cpu = 0; e_sys = 0; e_tag = "R4";
    endtask

    initial begin
        repeat (3) @(negedge clk);
        apply_reset();
        step(16'hCF9, 0, 1, 8'h00, "R4");     // cleared after reset
        step(16'hCF9, 1, 0, 8'h06, "R6");     // hard + cpu
        step(16'hCF9, 0, 1, 8'h00, "R3");     // stored 0x04 reads 0x00
        step(16'hCF9, 1, 0, 8'h06, "R7");     // already armed: nothing
        step(16'hCF9, 1, 0, 8'hF3, "R8");     // bit 2 low: no pulse
        step(16'hCF9, 0, 1, 8'h00, "R2");     // reads 0xF1
        step(16'hCF9, 1, 0, 8'h04, "R5");     // cpu only
        step(16'hCF9, 0, 0, 8'h00, "R9");     // pulse gone
        step(16'hCF9, 1, 0, 8'h00, "R8");
        step(16'hCFA, 1, 0, 8'h04, "R1");     // wrong address
        step(16'h0CF8, 1, 0, 8'hFF, "R1");
        step(16'hCF8, 0, 1, 8'h00, "R1");     // read elsewhere
        step(16'hCF9, 1, 0, 8'h04, "R1");     // still triggers: bit 2 was untouched
        step(16'hCF9, 1, 0, 8'h00, "R8");
        step(16'hCF9, 1, 0, 8'hFF, "R6");     // hard again
        step(16'hCF9, 0, 1, 8'h00, "R3");     // reads 0xF9
        step(16'hCF9, 0, 1, 8'h00, "R2");
        step(16'hCF9, 1, 0, 8'h02, "R8");     // bit 1 alone: no pulse
        step(16'hCF9, 1, 0, 8'h80, "R2");
        step(16'hCF9, 0, 1, 8'h00, "R2");
        apply_reset();
        step(16'hCF9, 0, 1, 8'h00, "R4");
        step(16'hCF9, 1, 0, 8'h04, "R5");
        step(16'hCF9, 0, 0, 8'h00, "R9");
        step(16'hCF9, 0, 0, 8'h00, "R9");
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog expired got 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule